// File: doc/BRIEF.md
# Two-Way Flash Read Cache

This block sits between a processor bus and a slow serial flash device. It keeps 8 KB of recently fetched flash contents and answers byte reads from that store. It has two ways of 128 sets, and each line holds 32 bytes. The flash is never written through this block.

A read is started with a one-cycle strobe and a 24-bit byte address. The block returns the byte together with a one-cycle ready pulse. The delay depends on how the read relates to earlier traffic:

- A read of the line touched by the previous completed access takes the shortest path.
- A read that hits any other stored line costs one more cycle.
- A miss requests the whole 32-byte line from the flash side and answers once the last byte of that line has been stored.

Only the low 22 address bits select flash contents. Accesses in the mirror windows above 4 MB therefore alias onto the same lines as the base range.

On the flash side, the block raises a line-fill request carrying a 32-byte-aligned address. It then takes the returned bytes in ascending order under a valid/ready handshake. Replacement keeps one least-recently-used bit per set. A separate register records the set, way and tag of the last line accessed, and this register is what selects the shortest path.

Top module: `flash_read_cache`

## Requirements
- R1: After reset no line is valid, `rd_ready` and `fill_req` are low, and the first read of any address is a miss.
- R2: The byte offset is address bits 4..0, the set index is bits 11..5, and the tag is bits 21..12. Two lines with the same set index and different tags are both kept, one in each way.
- R3: A read whose set and tag equal those of the previous completed access has `rd_ready` high in the second cycle after the strobe cycle (2 cycles in total). `rd_ready` is high for exactly one cycle per accepted read.
- R4: A read that hits a valid line other than the previously accessed one has `rd_ready` high in the third cycle after the strobe cycle (3 cycles in total).
- R5: On a miss, `fill_req` rises with `fill_addr` = {2'b00, addr[21:5], 5'b00000} and holds that address steady. Exactly 32 bytes are accepted, and each is taken on a clock edge where `fill_valid` and `fill_ready` are both high. `rd_ready` rises on the edge right after the edge that accepts the 32nd byte.
- R6: The returned byte equals the flash byte at address bits 21..0. Fill bytes are stored at line offsets 0 to 31 in the order they arrive.
- R7: On a miss the victim is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way of the set. Every hit and every fill marks the used way as most recent.
- R8: Addresses that differ only in bits 23..22 (other than 2'b11) select the same line: a read in a mirror window hits a line loaded through the base range and returns the same byte.
- R9: A strobe that arrives while a read is outstanding is ignored. It produces no response and no fill, and it leaves that address uncached.
- R10: A reset asserted during a fill drops the request, and no line that was being filled or was cached before is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | One-cycle read strobe, taken only when idle |
| rd_addr | input | 24 | Byte address of the read |
| rd_ready | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | 8 | Returned byte |
| fill_req | output | 1 | Line-fill request, held until the last byte is taken |
| fill_addr | output | 24 | Line-aligned flash address of the fill |
| fill_valid | input | 1 | Flash side presents a byte |
| fill_data | input | 8 | Byte from flash, in ascending address order |
| fill_ready | output | 1 | Block takes a byte on this edge when `fill_valid` is high |

## Verification
Directed sequences are applied first, and they separate the three latency classes on one set:

- The same-line repeat is told apart from a hit on the second way, and a third tag is used to expose the choice of replacement victim.
- Mirror-window addresses confirm that bits 23..22 alias instead of forming new tags.
- A strobe injected during a fill shows it is ignored.
- A reset applied mid-fill shows that previously cached lines come back as misses.

A seeded random phase then draws addresses from a few tags, two sets and three mirror windows, and revisits recent lines often. This mixes all three latency classes with evictions. Every response is compared against a bench reference for latency class, cycle count and data, with the flash model stalling at random.

// File: rtl/fcache_pkg.sv
package fcache_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SAME  = 3'd1,
        S_LOOK  = 3'd2,
        S_WAIT  = 3'd3,
        S_FILL  = 3'd4,
        S_FDONE = 3'd5,
        S_RESP  = 3'd6
    } fc_state_e;

endpackage

// File: rtl/fcache_tag_store.sv
module fcache_tag_store #(
    parameter int SETS  = 128,
    parameter int TAG_W = 10,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_W-1:0]      rd_set,
    output logic [1:0][TAG_W-1:0] rd_tag,
    output logic [1:0]            rd_vld,
    output logic                  rd_lru,
    input  logic [SET_W-1:0]      wr_set,
    input  logic                  wr_way,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic                  inv_en,
    input  logic                  val_en,
    input  logic                  touch_en
);

    // One valid vector and one tag array per way
    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else if (wr_way == 1'(w)) begin
                if (inv_en) begin
                    vld_q[wr_set] <= 1'b0;
                end else if (val_en) begin
                    vld_q[wr_set] <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (val_en && wr_way == 1'(w)) begin
                tag_q[wr_set] <= wr_tag;
            end
        end

        assign rd_vld[w] = vld_q[rd_set];
        assign rd_tag[w] = tag_q[rd_set];
    end

    // Per set: index of the least recently used way
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[wr_set] <= ~wr_way;
        end
    end

    assign rd_lru = lru_q[rd_set];

endmodule

// File: rtl/fcache_line_store.sv
module fcache_line_store #(
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 32,
    localparam int SET_W     = $clog2(SETS),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int DEPTH     = 2 * SETS
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wr_way,
    input  logic [SET_W-1:0] wr_set,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_byte,
    input  logic             rd_way,
    input  logic [SET_W-1:0] rd_set,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_byte
);

    logic [LINE_BYTES*8-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wr_way, wr_set}][{wr_off, 3'b000} +: 8] <= wr_byte;
        end
    end

    assign rd_byte = mem[{rd_way, rd_set}][{rd_off, 3'b000} +: 8];

endmodule

// File: rtl/flash_read_cache.sv
module flash_read_cache
    import fcache_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int FLASH_AW   = 22,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [7:0]        fill_data,
    output logic              fill_ready
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = FLASH_AW - OFF_W - SET_W;
    localparam int HI_W  = ADDR_W - FLASH_AW;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_BYTES - 1);

    typedef struct packed {
        fc_state_e        st;
        logic [SET_W-1:0] set;
        logic [OFF_W-1:0] off;
        logic [TAG_W-1:0] tag;
        logic             way;
        logic [OFF_W-1:0] cnt;
        logic             lvld;
        logic [SET_W-1:0] lset;
        logic [TAG_W-1:0] ltag;
        logic             lway;
        logic [7:0]       data;
    } regs_t;

    regs_t q, d;

    // Address split; bits above FLASH_AW alias (mirror windows)
    logic [SET_W-1:0] a_set;
    logic [OFF_W-1:0] a_off;
    logic [TAG_W-1:0] a_tag;
    logic             unused_hi;

    assign a_off     = rd_addr[OFF_W-1:0];
    assign a_set     = rd_addr[OFF_W +: SET_W];
    assign a_tag     = rd_addr[OFF_W+SET_W +: TAG_W];
    assign unused_hi = ^rd_addr[ADDR_W-1:FLASH_AW];

    // Store interfaces
    logic [1:0][TAG_W-1:0] ts_tag;
    logic [1:0]            ts_vld;
    logic                  ts_lru;
    logic                  ts_inv, ts_val, ts_touch, ts_way;
    logic                  ls_we;
    logic [7:0]            ls_byte;
    logic                  hit0, hit1, victim;

    fcache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (q.set),
        .rd_tag   (ts_tag),
        .rd_vld   (ts_vld),
        .rd_lru   (ts_lru),
        .wr_set   (q.set),
        .wr_way   (ts_way),
        .wr_tag   (q.tag),
        .inv_en   (ts_inv),
        .val_en   (ts_val),
        .touch_en (ts_touch)
    );

    fcache_line_store #(.SETS(SETS), .LINE_BYTES(LINE_BYTES)) u_lines (
        .clk     (clk),
        .we      (ls_we),
        .wr_way  (q.way),
        .wr_set  (q.set),
        .wr_off  (q.cnt),
        .wr_byte (fill_data),
        .rd_way  (q.way),
        .rd_set  (q.set),
        .rd_off  (q.off),
        .rd_byte (ls_byte)
    );

    assign hit0   = ts_vld[0] && (ts_tag[0] == q.tag);
    assign hit1   = ts_vld[1] && (ts_tag[1] == q.tag);
    assign victim = !ts_vld[0] ? 1'b0 : (!ts_vld[1] ? 1'b1 : ts_lru);

    always_comb begin
        d        = q;
        ts_inv   = 1'b0;
        ts_val   = 1'b0;
        ts_touch = 1'b0;
        ts_way   = q.way;
        ls_we    = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (rd_req) begin
                    d.set = a_set;
                    d.off = a_off;
                    d.tag = a_tag;
                    if (q.lvld && a_set == q.lset && a_tag == q.ltag) begin
                        d.way = q.lway;
                        d.st  = S_SAME;
                    end else begin
                        d.st  = S_LOOK;
                    end
                end
            end
            S_SAME, S_WAIT, S_FDONE: begin
                d.data = ls_byte;
                d.st   = S_RESP;
            end
            S_LOOK: begin
                if (hit0 || hit1) begin
                    d.way    = hit1;
                    ts_way   = hit1;
                    ts_touch = 1'b1;
                    d.lvld   = 1'b1;
                    d.lset   = q.set;
                    d.ltag   = q.tag;
                    d.lway   = hit1;
                    d.st     = S_WAIT;
                end else begin
                    d.way  = victim;
                    ts_way = victim;
                    ts_inv = 1'b1;
                    d.cnt  = '0;
                    d.st   = S_FILL;
                end
            end
            S_FILL: begin
                if (fill_valid) begin
                    ls_we = 1'b1;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BEAT) begin
                        ts_val   = 1'b1;
                        ts_touch = 1'b1;
                        d.lvld   = 1'b1;
                        d.lset   = q.set;
                        d.ltag   = q.tag;
                        d.lway   = q.way;
                        d.st     = S_FDONE;
                    end
                end
            end
            S_RESP:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_ready   = (q.st == S_RESP);
    assign rd_data    = q.data;
    assign fill_req   = (q.st == S_FILL);
    assign fill_ready = (q.st == S_FILL);
    assign fill_addr  = {{HI_W{1'b0}}, q.tag, q.set, {OFF_W{1'b0}}};

endmodule

// File: rtl/fcache_checker.sv
module fcache_checker #(
    parameter int ADDR_W     = 24,
    parameter int LINE_BYTES = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int BEAT_W    = OFF_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_ready,
    input logic              fill_req,
    input logic              fill_valid,
    input logic              fill_ready,
    input logic [ADDR_W-1:0] fill_addr
);

    logic [BEAT_W-1:0] beats;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats <= '0;
        end else if (!fill_req) begin
            beats <= '0;
        end else if (fill_valid && fill_ready) begin
            beats <= beats + 1'b1;
        end
    end

    a_r5_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> fill_addr[OFF_W-1:0] == '0);

    a_r5_fill_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && $past(fill_req) |-> $stable(fill_addr));

    a_r5_full_line: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fill_req) |-> beats == BEAT_W'(LINE_BYTES));

    a_r5_answer_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fill_req) |=> rd_ready);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    a_r9_no_answer_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> !fill_req);

endmodule

bind flash_read_cache fcache_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ready   (rd_ready),
    .fill_req   (fill_req),
    .fill_valid (fill_valid),
    .fill_ready (fill_ready),
    .fill_addr  (fill_addr)
);

// File: tb/tb_flash_read_cache.sv
module tb_flash_read_cache;

    localparam int FLASH_LAT = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [23:0] rd_addr = '0;
    logic        rd_ready;
    logic [7:0]  rd_data;
    logic        fill_req;
    logic [23:0] fill_addr;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_data = '0;
    logic        fill_ready;

    int total = 0;
    int bad = 0;
    int edge_cnt = 0;

    always #2 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    flash_read_cache dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .fill_req(fill_req),
        .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
        .fill_ready(fill_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fmem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b01};
    endfunction

    // ---------------- reference model (from R2, R3, R4, R7) ----------------
    bit         rv [2][128];
    bit [9:0]   rt [2][128];
    bit         rl [128];
    bit         lv;
    bit [6:0]   ls;
    bit [9:0]   lt;

    task automatic ref_reset();
        for (int s = 0; s < 128; s++) begin
            rv[0][s] = 0; rv[1][s] = 0; rl[s] = 0;
        end
        lv = 0;
    endtask

    // kind: 0 same line, 1 other hit, 2 miss
    task automatic ref_access(input logic [23:0] a, output int kind);
        bit [6:0] s = a[11:5];
        bit [9:0] t = a[21:12];
        bit       w;
        if (lv && s == ls && t == lt) begin
            kind = 0;
            return;
        end
        if (rv[0][s] && rt[0][s] == t) begin kind = 1; w = 0; end
        else if (rv[1][s] && rt[1][s] == t) begin kind = 1; w = 1; end
        else begin
            kind = 2;
            w = !rv[0][s] ? 1'b0 : (!rv[1][s] ? 1'b1 : rl[s]);
            rv[w][s] = 1; rt[w][s] = t;
        end
        rl[s] = ~w;
        lv = 1; ls = s; lt = t;
    endtask

    // ---------------- flash model ----------------
    logic [23:0] exp_fill = '0;
    bit          fm_busy = 0;
    int          fm_wait = 0;
    int          fm_idx = 0;
    logic [23:0] fm_base = '0;
    bit          pend = 0;
    int          pend_edge = 0;
    int          last_acc_edge = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            fm_busy = 0; fm_idx = 0; pend = 0; fill_valid = 1'b0;
        end else begin
            if (pend) begin
                fm_idx++;
                last_acc_edge = pend_edge;
            end
            if (!fm_busy && fill_req) begin
                fm_busy = 1; fm_wait = FLASH_LAT; fm_idx = 0; fm_base = fill_addr;
                chk(fill_addr == exp_fill, "R5", "fill address",
                    int'(fill_addr), int'(exp_fill));
            end
            if (fm_busy && fm_idx >= 32) fm_busy = 0;
            if (fm_busy) begin
                if (fm_wait > 0) begin
                    fm_wait--;
                    fill_valid = 1'b0;
                end else if ($urandom % 6 == 0) begin
                    fill_valid = 1'b0;
                end else begin
                    fill_valid = 1'b1;
                    fill_data  = fmem(fm_base + 24'(fm_idx));
                end
            end else begin
                fill_valid = 1'b0;
            end
            pend = fill_valid && fill_ready;
            pend_edge = edge_cnt + 1;
        end
    end

    // ---------------- read task ----------------
    task automatic do_read(input logic [23:0] a, input string req,
                           input bit poke, input logic [23:0] pa);
        int kind, start_e, rdy_e, n, cyc;
        bit got = 0;
        ref_access(a, kind);
        if (kind == 2) exp_fill = {2'b00, a[21:5], 5'b00000};
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        start_e = edge_cnt + 1;
        n = 0;
        while (!got && n < 3000) begin
            @(negedge clk);
            rd_req = 1'b0;
            n++;
            if (poke && n == 20) begin rd_req = 1'b1; rd_addr = pa; end
            if (rd_ready) begin got = 1; rdy_e = edge_cnt; end
        end
        if (!got) begin
            chk(0, req, "no response", 0, 1);
            return;
        end
        cyc = rdy_e - start_e + 1;
        chk(rd_data == fmem(a), {req, " R6"}, "data", int'(rd_data), int'(fmem(a)));
        if (kind == 0)      chk(cyc == 2, {req, " R3"}, "same-line cycles", cyc, 2);
        else if (kind == 1) chk(cyc == 3, {req, " R4"}, "hit cycles", cyc, 3);
        else                chk(rdy_e == last_acc_edge + 1, {req, " R5"}, "miss ready edge",
                                rdy_e, last_acc_edge + 1);
        @(negedge clk);
        chk(!rd_ready, "R3", "ready width", int'(rd_ready), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 190000);
        total++; bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [23:0] a, prev;
        void'($urandom(32'd4242));
        ref_reset();
        repeat (3) @(negedge clk);
        chk(!rd_ready && !fill_req, "R1", "reset outputs",
            int'({rd_ready, fill_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_read(24'h000123, "R1 first miss", 0, 0);
        do_read(24'h00013F, "R3 same line", 0, 0);
        do_read(24'h001120, "R2 second way", 0, 0);
        do_read(24'h000125, "R2 R4 way0 kept", 0, 0);
        do_read(24'h000126, "R3 repeat", 0, 0);
        do_read(24'h40012A, "R8 mirror same line", 0, 0);
        do_read(24'h801125, "R8 mirror other way", 0, 0);
        do_read(24'h002120, "R7 evict lru", 0, 0);
        do_read(24'h001121, "R7 mru kept", 0, 0);
        do_read(24'h000120, "R7 evicted misses", 0, 0);

        // R9: strobe during a fill is ignored
        do_read(24'h0053C0, "R9 fill with poke", 1, 24'h006A40);
        repeat (4) begin
            @(negedge clk);
            chk(!rd_ready && !fill_req, "R9", "extra activity",
                int'({rd_ready, fill_req}), 0);
        end
        do_read(24'h006A40, "R9 poked addr misses", 0, 0);

        // R10: reset during a fill
        exp_fill = 24'h007700;
        @(negedge clk); rd_req = 1'b1; rd_addr = 24'h007705;
        @(negedge clk); rd_req = 1'b0;
        repeat (FLASH_LAT + 12) @(negedge clk);
        chk(fill_req, "R10", "fill in progress", int'(fill_req), 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!fill_req && !rd_ready, "R10", "reset drops fill",
            int'({fill_req, rd_ready}), 0);
        rst_n = 1'b1;
        ref_reset();
        do_read(24'h007705, "R10 aborted line misses", 0, 0);
        do_read(24'h001121, "R10 old line misses", 0, 0);

        // random phase
        prev = 24'h001121;
        for (int i = 0; i < 250; i++) begin
            if ($urandom % 10 < 3) begin
                a = {prev[23:5], 5'($urandom)};
            end else begin
                a = {2'($urandom % 3), 10'($urandom % 4),
                     ($urandom % 2 == 0) ? 7'd3 : 7'd77, 5'($urandom)};
            end
            do_read(a, "R6 random", 0, 0);
            prev = a;
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule